// File: doc/BRIEF.md
# Four-Bank SDRAM Command Sequencer

This block sits on the controller side of a four-bank SDRAM. It takes one access request at a time (bank, row, column, read or write, and a flag that asks the row to close itself after the burst) and turns it into the command sequence the memory expects. It remembers which row is open in each bank. A request that finds its row already open goes straight to the column command. A request to an idle bank first opens the row. A request that finds a different row open first closes that bank and then opens the new row.

Each bank has its own down-counter for the minimum spacing after opening, closing and refreshing. Because of this, a bank that is closing itself after a burst does not hold up an open command to a different bank. A free-running interval timer raises a refresh request. Once the current access has finished, the sequencer closes every open bank with one command and then issues an auto-refresh. No new row is opened while that is in progress.

Top module: `sdramCmdSeq`

## Requirements
- R1: While reset is held, chip select is high. After reset is released, the command output is a NOP with chip select low, and `reqReady` is high.
- R2: Each command is driven with chip select low, and {RAS#,CAS#,WE#} is one of: open row 011, read 101, write 100, close 010, refresh 001, NOP 111. An open-row command carries the row on the low address bits. A read or write carries the column on the low bits and the auto-close flag on address bit 10. A close command with bit 10 low closes only the named bank; with bit 10 high it closes all banks.
- R3: A request whose row is already open in its bank produces the read or write with no close and no open-row command before it.
- R4: A request to an idle bank produces exactly one open-row command, with the requested bank and row, and no close. The read or write follows no sooner than T_RCD cycles after that open-row command.
- R5: A request to a bank holding a different row produces one close of that bank and then one open-row command. The open-row command comes no sooner than T_RP cycles after the close.
- R6: A read or write with the auto-close flag leaves its bank idle without any close command. The next open-row command to that bank comes no sooner than BURST_LEN + T_RP cycles after the read or write.
- R7: Successive reads or writes are at least BURST_LEN cycles apart. No close command comes within BURST_LEN cycles of the last read or write.
- R8: A refresh occurs at most REF_INTERVAL + 40 cycles after the previous one (or after reset). It is issued only when all banks are idle, at least T_RP cycles after any close. No open-row command follows it within T_RFC cycles.
- R9: `reqReady` is low from the cycle after a request is accepted until its read or write is issued. It is also low from a close-all command until the refresh that follows it. Each handshake is served by exactly one read or write.
- R10: An open-row command to one bank may be issued while another bank is still inside its burst. In particular, it may come fewer than BURST_LEN cycles after that bank's read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is present on the request fields |
| reqReady | output | 1 | The sequencer takes the request on this edge if reqValid is high |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Starting column |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAutoPre | input | 1 | Close the row automatically after the burst |
| cmdCsN | output | 1 | Chip select, active low |
| cmdRasN | output | 1 | Row strobe, active low |
| cmdCasN | output | 1 | Column strobe, active low |
| cmdWeN | output | 1 | Write enable, active low |
| cmdBank | output | BANK_W | Bank field of the command |
| cmdAddr | output | ADDR_W | Row, column or close-all flag, depending on the command |

## Verification
The bench keeps its own record of the open row in every bank and the earliest legal cycle for each command. From that record it works out whether each accepted request is a hit, a miss or a cold bank. A design that compared rows wrongly would show an unexpected close or a missing one. A design that left a bank marked open after an auto-close would skip the open-row command and read from a closed bank. Directed cases cover hit, miss, auto-close followed by reuse of the same bank, and an open-row command to a second bank that overlaps the first bank's burst. A design that serialised on a global timer would miss that overlap window. Random traffic over few rows mixes these cases with refreshes that arrive in the middle of sequences, and the spacing checks catch any counter that is loaded one cycle short.

// File: rtl/seqPkg.sv
package seqPkg;

  // {RAS#,CAS#,WE#} with chip select low
  typedef enum logic [2:0] {
    CMD_REF   = 3'b001,
    CMD_PRE   = 3'b010,
    CMD_ACT   = 3'b011,
    CMD_WRITE = 3'b100,
    CMD_READ  = 3'b101,
    CMD_NOP   = 3'b111
  } sdCmd_t;

  // control -> datapath strobes, at most one command strobe per cycle
  typedef struct packed {
    logic latch;
    logic doAct;
    logic doRdWr;
    logic doPre;
    logic doPreAll;
    logic doRef;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic curOpen;
    logic curHit;
    logic curTmrZero;
    logic allTmrZero;
    logic anyOpen;
    logic burstIdle;
  } dpStatus_t;

endpackage

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
#(
  parameter int REF_INTERVAL = 780
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  dpStatus_t  stat,
  output logic       reqReady,
  output ctlStrobe_t strb
);

  localparam int REF_W = $clog2(REF_INTERVAL + 1);

  typedef enum logic {ST_IDLE, ST_ISSUE} seqState_t;

  seqState_t        state, stateNext;
  logic [REF_W-1:0] refCnt;
  logic             refPending;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      state <= stateNext;
      if (refCnt == REF_W'(REF_INTERVAL - 1)) begin
        refCnt     <= '0;
        refPending <= 1'b1;
      end else begin
        refCnt <= refCnt + REF_W'(1);
        if (strb.doRef) refPending <= 1'b0;
      end
    end
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    reqReady  = (state == ST_IDLE) && !refPending;
    case (state)
      ST_IDLE: begin
        if (refPending) begin
          // wait for the burst and all bank timers, close everything, refresh
          if (stat.burstIdle && stat.allTmrZero) begin
            if (stat.anyOpen) strb.doPreAll = 1'b1;
            else              strb.doRef    = 1'b1;
          end
        end else if (reqValid) begin
          strb.latch = 1'b1;
          stateNext  = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (stat.curHit) begin
          if (stat.curTmrZero && stat.burstIdle) begin
            strb.doRdWr = 1'b1;
            stateNext   = ST_IDLE;
          end
        end else if (stat.curOpen) begin
          if (stat.curTmrZero && stat.burstIdle) strb.doPre = 1'b1;
        end else begin
          // open-row may overlap another bank's burst
          if (stat.curTmrZero) strb.doAct = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 12,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 7,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strb,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  input  logic              reqAutoPre,
  output dpStatus_t         stat,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr
);

  localparam int AP_BIT  = 10;
  localparam int TMR_W   = $clog2(T_RCD + T_RP + T_RFC + BURST_LEN + 1);
  localparam int BURST_W = $clog2(BURST_LEN + 1);

  // latched request
  logic [BANK_W-1:0] curBank;
  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  logic              curWrite;
  logic              curAp;

  always_ff @(posedge clk) begin
    if (rst) begin
      curBank  <= '0;
      curRow   <= '0;
      curCol   <= '0;
      curWrite <= 1'b0;
      curAp    <= 1'b0;
    end else if (strb.latch) begin
      curBank  <= reqBank;
      curRow   <= reqRow;
      curCol   <= reqCol;
      curWrite <= reqWrite;
      curAp    <= reqAutoPre;
    end
  end

  // per-bank open-row table and spacing timers
  logic [NUM_BANKS-1:0] openVec;
  logic [NUM_BANKS-1:0] zeroVec;
  logic [ROW_W-1:0]     rowArr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             openB;
    logic [ROW_W-1:0] rowB;
    logic [TMR_W-1:0] tmrB;
    logic             selB;

    assign selB = (curBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        openB <= 1'b0;
        rowB  <= '0;
        tmrB  <= '0;
      end else if (strb.doAct && selB) begin
        openB <= 1'b1;
        rowB  <= curRow;
        tmrB  <= TMR_W'(T_RCD - 1);
      end else if (strb.doRdWr && selB && curAp) begin
        openB <= 1'b0;
        tmrB  <= TMR_W'(BURST_LEN + T_RP - 1);
      end else if ((strb.doPre && selB) || strb.doPreAll) begin
        openB <= 1'b0;
        tmrB  <= TMR_W'(T_RP - 1);
      end else if (strb.doRef) begin
        tmrB  <= TMR_W'(T_RFC - 1);
      end else if (tmrB != '0) begin
        tmrB  <= tmrB - TMR_W'(1);
      end
    end

    assign openVec[b] = openB;
    assign zeroVec[b] = (tmrB == '0);
    assign rowArr[b]  = rowB;
  end

  // burst occupancy of the data bus
  logic [BURST_W-1:0] burstCnt;

  always_ff @(posedge clk) begin
    if (rst)                  burstCnt <= '0;
    else if (strb.doRdWr)     burstCnt <= BURST_W'(BURST_LEN - 1);
    else if (burstCnt != '0)  burstCnt <= burstCnt - BURST_W'(1);
  end

  always_comb begin
    stat.curOpen    = openVec[curBank];
    stat.curHit     = openVec[curBank] && (rowArr[curBank] == curRow);
    stat.curTmrZero = zeroVec[curBank];
    stat.allTmrZero = &zeroVec;
    stat.anyOpen    = |openVec;
    stat.burstIdle  = (burstCnt == '0);
  end

  // registered command output
  logic [ADDR_W-1:0] colAddr, allAddr;
  sdCmd_t            cmdQ;
  logic              csQ;

  always_comb begin
    colAddr         = ADDR_W'(curCol);
    colAddr[AP_BIT] = curAp;
    allAddr         = '0;
    allAddr[AP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csQ     <= 1'b1;
      cmdQ    <= CMD_NOP;
      cmdBank <= '0;
      cmdAddr <= '0;
    end else begin
      csQ     <= 1'b0;
      cmdQ    <= CMD_NOP;
      cmdBank <= '0;
      cmdAddr <= '0;
      if (strb.doAct) begin
        cmdQ    <= CMD_ACT;
        cmdBank <= curBank;
        cmdAddr <= ADDR_W'(curRow);
      end else if (strb.doRdWr) begin
        cmdQ    <= curWrite ? CMD_WRITE : CMD_READ;
        cmdBank <= curBank;
        cmdAddr <= colAddr;
      end else if (strb.doPre) begin
        cmdQ    <= CMD_PRE;
        cmdBank <= curBank;
      end else if (strb.doPreAll) begin
        cmdQ    <= CMD_PRE;
        cmdAddr <= allAddr;
      end else if (strb.doRef) begin
        cmdQ    <= CMD_REF;
      end
    end
  end

  assign cmdCsN  = csQ;
  assign cmdRasN = cmdQ[2];
  assign cmdCasN = cmdQ[1];
  assign cmdWeN  = cmdQ[0];

endmodule

// File: rtl/sdramCmdSeq.sv
module sdramCmdSeq
  import seqPkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int ADDR_W       = 12,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 7,
  parameter int BURST_LEN    = 4,
  parameter int REF_INTERVAL = 780,
  localparam int BANK_W      = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  input  logic              reqAutoPre,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr
);

  ctlStrobe_t strb;
  dpStatus_t  stat;

  seqControl #(
    .REF_INTERVAL(REF_INTERVAL)
  ) i_seqControl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .stat     (stat),
    .reqReady (reqReady),
    .strb     (strb)
  );

  seqDatapath #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .ADDR_W    (ADDR_W),
    .T_RCD     (T_RCD),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC),
    .BURST_LEN (BURST_LEN)
  ) i_seqDatapath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .reqBank    (reqBank),
    .reqRow     (reqRow),
    .reqCol     (reqCol),
    .reqWrite   (reqWrite),
    .reqAutoPre (reqAutoPre),
    .stat       (stat),
    .cmdCsN     (cmdCsN),
    .cmdRasN    (cmdRasN),
    .cmdCasN    (cmdCasN),
    .cmdWeN     (cmdWeN),
    .cmdBank    (cmdBank),
    .cmdAddr    (cmdAddr)
  );

endmodule

// File: rtl/seqChecker.sv
module seqChecker #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              cmdCsN,
  input logic              cmdRasN,
  input logic              cmdCasN,
  input logic              cmdWeN,
  input logic [BANK_W-1:0] cmdBank,
  input logic              apBit
);

  logic [2:0] kind;
  logic       isAct, isRdWr, isPre, isRef;

  assign kind   = {cmdRasN, cmdCasN, cmdWeN};
  assign isAct  = !cmdCsN && (kind == 3'b011);
  assign isRdWr = !cmdCsN && ((kind == 3'b101) || (kind == 3'b100));
  assign isPre  = !cmdCsN && (kind == 3'b010);
  assign isRef  = !cmdCsN && (kind == 3'b001);

  logic [NUM_BANKS-1:0] openMask;
  logic [CNT_W-1:0]     sinceRdWr;

  always_ff @(posedge clk) begin
    if (rst) begin
      openMask  <= '0;
      sinceRdWr <= CNT_W'(BURST_LEN);
    end else begin
      if (isAct) openMask[cmdBank] <= 1'b1;
      if (isRdWr && apBit) openMask[cmdBank] <= 1'b0;
      if (isPre) begin
        if (apBit) openMask <= '0;
        else       openMask[cmdBank] <= 1'b0;
      end
      if (isRdWr)                              sinceRdWr <= CNT_W'(1);
      else if (sinceRdWr < CNT_W'(BURST_LEN))  sinceRdWr <= sinceRdWr + CNT_W'(1);
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !cmdCsN |-> (kind inside {3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b111})); // R2

  AST_ROW_OPEN_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    isAct |-> !openMask[cmdBank]); // R4

  AST_COLUMN_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
    isRdWr |-> openMask[cmdBank]); // R3

  AST_REFRESH_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    isRef |-> (openMask == '0)); // R8

  AST_BURST_SPACING: assert property (@(posedge clk) disable iff (rst)
    (isRdWr || isPre) |-> (sinceRdWr >= CNT_W'(BURST_LEN))); // R7

  AST_BUSY_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
    (isPre && apBit) |-> !reqReady); // R9

endmodule

bind sdramCmdSeq seqChecker #(
  .NUM_BANKS (NUM_BANKS),
  .BURST_LEN (BURST_LEN)
) i_seqChecker (
  .clk      (clk),
  .rst      (rst),
  .reqReady (reqReady),
  .cmdCsN   (cmdCsN),
  .cmdRasN  (cmdRasN),
  .cmdCasN  (cmdCasN),
  .cmdWeN   (cmdWeN),
  .cmdBank  (cmdBank),
  .apBit    (cmdAddr[10])
);

// File: tb/test_sdramCmdSeq.sv
`timescale 1ns/1ps
module test_sdramCmdSeq;

  localparam int NB    = 4;
  localparam int BW    = 2;
  localparam int RW    = 12;
  localparam int CW    = 10;
  localparam int AW    = 12;
  localparam int TRCD  = 2;
  localparam int TRP   = 3;
  localparam int TRFC  = 6;
  localparam int BL    = 4;
  localparam int REFI  = 300;
  localparam int SLACK = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [BW-1:0] reqBank = '0;
  logic [RW-1:0] reqRow = '0;
  logic [CW-1:0] reqCol = '0;
  logic          reqWrite = 1'b0;
  logic          reqAutoPre = 1'b0;
  logic          cmdCsN, cmdRasN, cmdCasN, cmdWeN;
  logic [BW-1:0] cmdBank;
  logic [AW-1:0] cmdAddr;

  always #10 clk = ~clk;

  sdramCmdSeq #(
    .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .ADDR_W(AW),
    .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .BURST_LEN(BL), .REF_INTERVAL(REFI)
  ) i_sdramCmdSeq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqWrite(reqWrite),
    .reqAutoPre(reqAutoPre), .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN),
    .cmdWeN(cmdWeN), .cmdBank(cmdBank), .cmdAddr(cmdAddr)
  );

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  done   = 0;
  bit  live   = 0;

  // bench model of the memory state
  bit  openB   [NB];
  int  openRow [NB];
  int  readyAt [NB];
  int  actAt   [NB];
  int  lastRd  [NB];
  int  lastRdWr  = -1000;
  int  lastRef   = 0;
  int  refCount  = 0;
  bit  refInProg = 0;
  bit  probeR10  = 0;

  // outstanding request
  bit    pend = 0;
  int    rqBank, rqRow, rqCol, rqWr, rqAp;
  int    expPre, expAct, seenPre, seenAct;
  string expTag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit allClosed();
    for (int i = 0; i < NB; i++) if (openB[i]) return 0;
    return 1;
  endfunction

  function automatic int maxReady();
    int m = 0;
    for (int i = 0; i < NB; i++) if (readyAt[i] > m) m = readyAt[i];
    return m;
  endfunction

  initial begin
    for (int i = 0; i < NB; i++) begin
      openB[i] = 0; openRow[i] = 0; readyAt[i] = 0; actAt[i] = -1000; lastRd[i] = -1000;
    end
  end

  always @(posedge clk) live <= !rst;

  // monitor: samples 2 ns after the falling edge
  always @(negedge clk) begin
    #2;
    if (live) begin
      int kind, bk;
      cyc++;
      kind = {cmdRasN, cmdCasN, cmdWeN};
      bk   = int'(cmdBank);
      chk(cmdCsN == 1'b0, "R2 chip select", cmdCsN, 0);
      case (kind)
        3'b011: begin
          chk(!openB[bk], "R4 open-row on open bank", openB[bk], 0);
          chk(cyc >= readyAt[bk], "R5 R6 R8 open-row spacing", cyc, readyAt[bk]);
          chk(pend && bk == rqBank, "R4 open-row bank", bk, rqBank);
          chk(int'(cmdAddr) == rqRow, "R4 open-row row", cmdAddr, rqRow);
          if (probeR10 && bk == 1) begin
            chk(cyc - lastRd[0] < BL, "R10 overlap", cyc - lastRd[0], BL - 1);
            probeR10 = 0;
          end
          openB[bk] = 1; openRow[bk] = int'(cmdAddr); actAt[bk] = cyc;
          seenAct++;
        end
        3'b101, 3'b100: begin
          chk(openB[bk], "R3 column on idle bank", openB[bk], 1);
          chk(cyc >= actAt[bk] + TRCD, "R4 open-to-column", cyc - actAt[bk], TRCD);
          chk(cyc >= lastRdWr + BL, "R7 column spacing", cyc - lastRdWr, BL);
          chk(pend, "R9 column without request", pend, 1);
          chk(bk == rqBank, "R2 column bank", bk, rqBank);
          chk(int'(cmdAddr[CW-1:0]) == rqCol, "R2 column address", cmdAddr[CW-1:0], rqCol);
          chk(int'(kind == 3'b100) == rqWr, "R2 read or write", kind, rqWr ? 4 : 5);
          chk(int'(cmdAddr[10]) == rqAp, "R6 auto-close bit", cmdAddr[10], rqAp);
          chk(seenPre == expPre, {expTag, " close count"}, seenPre, expPre);
          chk(seenAct == expAct, {expTag, " open-row count"}, seenAct, expAct);
          if (cmdAddr[10]) begin
            openB[bk] = 0;
            readyAt[bk] = cyc + BL + TRP;
          end
          lastRdWr = cyc; lastRd[bk] = cyc;
          pend = 0;
        end
        3'b010: begin
          chk(cyc >= lastRdWr + BL, "R7 close after column", cyc - lastRdWr, BL);
          if (cmdAddr[10]) begin
            chk(!pend, "R8 close-all during request", pend, 0);
            for (int i = 0; i < NB; i++) begin openB[i] = 0; readyAt[i] = cyc + TRP; end
            refInProg = 1;
          end else begin
            chk(pend && bk == rqBank, "R5 close bank", bk, rqBank);
            chk(openB[bk], "R5 close of idle bank", openB[bk], 1);
            openB[bk] = 0; readyAt[bk] = cyc + TRP;
            seenPre++;
          end
        end
        3'b001: begin
          chk(allClosed(), "R8 refresh with open bank", 0, 1);
          chk(cyc >= maxReady(), "R8 refresh spacing", cyc, maxReady());
          chk(cyc - lastRef <= REFI + SLACK, "R8 refresh interval", cyc - lastRef, REFI + SLACK);
          chk(!pend, "R8 refresh inside request", pend, 0);
          for (int i = 0; i < NB; i++) readyAt[i] = cyc + TRFC;
          refCount++; lastRef = cyc; refInProg = 0;
        end
        3'b111: ;
        default: chk(0, "R2 illegal encoding", kind, 7);
      endcase
      if ((pend || refInProg) && reqReady) chk(0, "R9 ready while busy", 1, 0);
      if (reqValid && reqReady) begin
        pend = 1;
        rqBank = int'(reqBank); rqRow = int'(reqRow); rqCol = int'(reqCol);
        rqWr = int'(reqWrite); rqAp = int'(reqAutoPre);
        seenPre = 0; seenAct = 0;
        if (openB[rqBank] && openRow[rqBank] == rqRow) begin
          expPre = 0; expAct = 0; expTag = "R3";
        end else if (openB[rqBank]) begin
          expPre = 1; expAct = 1; expTag = "R5";
        end else begin
          expPre = 0; expAct = 1; expTag = "R4 R6";
        end
      end
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic sendReq(input int b, input int r, input int c, input bit w, input bit ap);
    reqValid = 1'b1;
    reqBank = BW'(b); reqRow = RW'(r); reqCol = CW'(c);
    reqWrite = w; reqAutoPre = ap;
    #2;
    while (!reqReady) begin
      @(negedge clk); #2;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (pend) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    chk(cmdCsN == 1'b1, "R1 deselect in reset", cmdCsN, 1);
    rst = 1'b0;
    @(negedge clk); #3;
    chk(cmdCsN == 1'b0 && {cmdRasN, cmdCasN, cmdWeN} == 3'b111, "R1 NOP after reset",
        {cmdCsN, cmdRasN, cmdCasN, cmdWeN}, 7);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    @(negedge clk);

    // directed corners
    sendReq(0, 5, 8, 0, 0);   // idle bank: R4
    sendReq(0, 5, 9, 1, 0);   // hit: R3
    sendReq(0, 7, 3, 0, 0);   // miss: R5
    sendReq(0, 7, 4, 0, 1);   // hit with auto-close: R6
    probeR10 = 1;
    sendReq(1, 2, 6, 0, 0);   // other bank during burst: R10
    sendReq(0, 7, 1, 1, 0);   // reuse after auto-close, no close cmd: R6
    waitIdle();
    chk(!probeR10, "R10 overlap probe resolved", probeR10, 0);

    while (refCount == 0) @(negedge clk);
    chk(refCount >= 1, "R8 first refresh", refCount, 1);

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      sendReq(int'($urandom % NB), int'($urandom % 3), int'($urandom % 1024),
              1'($urandom % 2), ($urandom % 4) == 0);
      if ($urandom % 5 == 0) repeat ($urandom % 6) @(negedge clk);
    end
    waitIdle();
    repeat (20) @(negedge clk);
    chk(cyc - lastRef <= REFI + SLACK, "R8 refresh interval at end", cyc - lastRef, REFI + SLACK);
    chk(refCount >= 2, "R8 refresh count", refCount, 2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule